// File: doc/BRIEF.md
# SPI Master Data-Line Timing Adjuster

This block sits between an SPI master's shift engine and its pads and shifts the timing of the serial data lines in whole system-clock cycles. The outgoing data bit from the engine can be held back by zero to three cycles before it reaches the pad. The incoming pad bit can likewise be held back by zero to three cycles before it is used. Independently, the point at which the incoming bit is captured can be moved relative to the engine's nominal sampling pulse, from two cycles ahead of it to one cycle after it.

Early capture works without knowing the future. The block keeps a short registered history of the incoming line and, one cycle after the nominal pulse, picks the history tap that matches the requested offset. The capture result therefore leaves the block a fixed two cycles after each sampling pulse, whatever offset is chosen. The settings are loaded from a 32-bit control word. The word is accepted only while the engine reports that no burst is running, so the timing never changes in the middle of a burst.

Typical use: larger clock divide ratios pair with longer input delays (one, two or three cycles at ratios of at least 6, 8 and 16). Fast source clocks pair with a capture offset (one cycle late at 100 MHz and above, nominal from 80 MHz). That choice is made outside this block.

Top module: `spi_io_timing_adj`

## Requirements
- R1: After reset all three fields read as zero: the outgoing line passes straight through, the incoming line is undelayed, capture uses the two-cycles-early tap, and `cap_valid` is low.
- R2: Control bits 17:16 give N in 0..3, and `mosi_pad` in each cycle equals `mosi_core` from N cycles earlier.
- R3: Control bits 19:18 give M in 0..3, and the line seen by the capture stage in each cycle equals `miso_pad` from M cycles earlier.
- R4: Control bits 21:20 select the capture offset relative to the cycle of the `sample_strobe` pulse. Code 0 takes the delayed line two cycles before the pulse, code 1 one cycle before, code 2 in the pulse cycle and code 3 one cycle after.
- R5: Each cycle with `sample_strobe` high produces exactly one cycle of `cap_valid` two cycles later, and this holds for back-to-back pulses. `cap_valid` is never high otherwise.
- R6: A control write (`cfg_we` high) takes effect from the next cycle only if `burst_active` is low in the write cycle. A write while `burst_active` is high changes nothing. Bits outside 21:16 have no effect.
- R7: Input delay and capture offset add up: with input delay M and capture code C, the bit presented with the pulse in cycle t equals `miso_pad` from cycle t + C - 2 - M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every delay step is one period |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_active | input | 1 | High while the shift engine runs a burst; blocks control writes |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 32 | Control word; delay and capture fields at bits 21:16 |
| mosi_core | input | 1 | Outgoing data bit from the shift engine |
| mosi_pad | output | 1 | Outgoing data bit after the output delay |
| miso_pad | input | 1 | Incoming data bit from the pad |
| sample_strobe | input | 1 | One-cycle pulse at the engine's nominal sampling point |
| cap_valid | output | 1 | Valid for the captured bit, two cycles after each pulse |
| cap_bit | output | 1 | Captured incoming bit at the selected offset |

## Verification
The capture output is valid-only and has no ready, because a serial line cannot be stalled. The checks take it as given that the engine holds `mosi_core`, `miso_pad`, `sample_strobe` and `burst_active` low during reset. The checks of capture timing also assume that no sampling pulse falls within two cycles of an accepted control write. The stimulus only writes the control word in idle gaps with `burst_active` low and places pulses well inside each burst, away from those writes. The one exception is the deliberate write during a burst, which must be ignored.

// File: rtl/spi_iotadj_pkg.sv
package spi_iotadj_pkg;
  // Control-word geometry; positions are decoded by the register neighbour.
  localparam int CFG_W       = 32;
  localparam int DLY_W       = 2;
  localparam int OUT_DLY_LSB = 16;
  localparam int IN_DLY_LSB  = 18;
  localparam int CAP_LSB     = 20;

  // Capture offset relative to the nominal sampling pulse.
  typedef enum logic [DLY_W-1:0] {
    CAP_EARLY2  = 2'd0,
    CAP_EARLY1  = 2'd1,
    CAP_NOMINAL = 2'd2,
    CAP_LATE1   = 2'd3
  } cap_code_e;
endpackage

// File: rtl/spi_iotadj_dline.sv
// Tapped delay line: dout equals din delayed by sel cycles (0 = combinational).
module spi_iotadj_dline #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  localparam int DEPTH = (1 << SEL_W) - 1;

  logic [DEPTH:0] taps;
  assign taps[0] = din;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[k] <= 1'b0;
      else        taps[k] <= taps[k-1];
    end
  end

  assign dout = taps[sel];
endmodule

// File: rtl/spi_iotadj_cfg.sv
// Holds the three timing fields; writes are accepted only outside a burst.
module spi_iotadj_cfg
  import spi_iotadj_pkg::*;
#(
  parameter int W       = CFG_W,
  parameter int FW      = DLY_W,
  parameter int OUT_LSB = OUT_DLY_LSB,
  parameter int IN_LSB  = IN_DLY_LSB,
  parameter int CP_LSB  = CAP_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          busy,
  input  logic [W-1:0]  wdata,
  output logic [FW-1:0] out_dly,
  output logic [FW-1:0] in_dly,
  output cap_code_e     cap_sel
);
  localparam logic [W-1:0] FMASK    = W'((1 << FW) - 1);
  localparam logic [W-1:0] USED_MSK = (FMASK << OUT_LSB) | (FMASK << IN_LSB) | (FMASK << CP_LSB);

  logic accept;
  logic wdata_unused;

  assign accept       = we && !busy;
  assign wdata_unused = ^(wdata & ~USED_MSK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_dly <= '0;
      in_dly  <= '0;
      cap_sel <= CAP_EARLY2;
    end else if (accept) begin
      out_dly <= wdata[OUT_LSB +: FW];
      in_dly  <= wdata[IN_LSB +: FW];
      cap_sel <= cap_code_e'(wdata[CP_LSB +: FW]);
    end
  end
endmodule

// File: rtl/spi_iotadj_capture.sv
// Capture stage: history of the delayed incoming line, tap chosen one cycle
// after the nominal pulse, result registered two cycles after the pulse.
module spi_iotadj_capture
  import spi_iotadj_pkg::*;
#(
  parameter int SEL_W = DLY_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line,
  input  logic      strobe,
  input  cap_code_e cap_sel,
  output logic      valid,
  output logic      bit_out
);
  // Tap 0 is the line one cycle after the pulse (late); each deeper tap is
  // one cycle older, so the deepest tap is two cycles before the pulse.
  localparam int HIST_DEPTH = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] tap_sel;
  logic             tap_bit;
  logic             strobe_q;

  assign tap_sel = SEL_W'(HIST_DEPTH) - SEL_W'(cap_sel);

  spi_iotadj_dline #(.SEL_W(SEL_W)) hist_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line),
    .sel  (tap_sel),
    .dout (tap_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      valid    <= 1'b0;
      bit_out  <= 1'b0;
    end else begin
      strobe_q <= strobe;
      valid    <= strobe_q;
      if (strobe_q) bit_out <= tap_bit;
    end
  end
endmodule

// File: rtl/spi_io_timing_adj.sv
module spi_io_timing_adj
  import spi_iotadj_pkg::*;
#(
  parameter int W  = CFG_W,
  parameter int FW = DLY_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         burst_active,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  input  logic         mosi_core,
  output logic         mosi_pad,
  input  logic         miso_pad,
  input  logic         sample_strobe,
  output logic         cap_valid,
  output logic         cap_bit
);
  logic [FW-1:0] cfg_out_dly;
  logic [FW-1:0] cfg_in_dly;
  cap_code_e     cfg_cap_sel;
  logic          miso_dly;

  spi_iotadj_cfg #(
    .W(W), .FW(FW),
    .OUT_LSB(OUT_DLY_LSB), .IN_LSB(IN_DLY_LSB), .CP_LSB(CAP_LSB)
  ) cfg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .busy   (burst_active),
    .wdata  (cfg_wdata),
    .out_dly(cfg_out_dly),
    .in_dly (cfg_in_dly),
    .cap_sel(cfg_cap_sel)
  );

  spi_iotadj_dline #(.SEL_W(FW)) out_dl_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (mosi_core),
    .sel  (cfg_out_dly),
    .dout (mosi_pad)
  );

  spi_iotadj_dline #(.SEL_W(FW)) in_dl_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (miso_pad),
    .sel  (cfg_in_dly),
    .dout (miso_dly)
  );

  spi_iotadj_capture #(.SEL_W(FW)) cap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .line   (miso_dly),
    .strobe (sample_strobe),
    .cap_sel(cfg_cap_sel),
    .valid  (cap_valid),
    .bit_out(cap_bit)
  );
endmodule

// File: rtl/spi_iotadj_chk.sv
module spi_iotadj_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       burst_active,
  input logic       mosi_core,
  input logic       mosi_pad,
  input logic       miso_pad,
  input logic       sample_strobe,
  input logic       cap_valid,
  input logic       cap_bit,
  input logic [1:0] od,
  input logic [1:0] id,
  input logic [1:0] cs
);
  AST_OUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (od == 2'd0) |-> (mosi_pad == mosi_core)); // R2
  AST_OUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (od == 2'd1) |-> (mosi_pad == $past(mosi_core))); // R2
  AST_CAP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> ##2 cap_valid); // R5
  AST_CAP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> $past(sample_strobe, 2)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(burst_active) |-> ($stable(od) && $stable(id) && $stable(cs))); // R6
  AST_CAP_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cs == 2'd2 && id == 2'd0 && $past(cs) == 2'd2 && $past(id) == 2'd0)
    |-> (cap_bit == $past(miso_pad, 2))); // R4
endmodule

bind spi_io_timing_adj spi_iotadj_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .burst_active (burst_active),
  .mosi_core    (mosi_core),
  .mosi_pad     (mosi_pad),
  .miso_pad     (miso_pad),
  .sample_strobe(sample_strobe),
  .cap_valid    (cap_valid),
  .cap_bit      (cap_bit),
  .od           (cfg_out_dly),
  .id           (cfg_in_dly),
  .cs           (cfg_cap_sel)
);

// File: tb/spi_io_timing_adj_tb.sv
module spi_io_timing_adj_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_active = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        mosi_core = 1'b0;
  logic        miso_pad = 1'b0;
  logic        sample_strobe = 1'b0;
  logic        mosi_pad, cap_valid, cap_bit;

  always #2.5 clk = ~clk;

  spi_io_timing_adj dut_i (
    .clk(clk), .rst_n(rst_n), .burst_active(burst_active),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mosi_core(mosi_core), .mosi_pad(mosi_pad),
    .miso_pad(miso_pad), .sample_strobe(sample_strobe),
    .cap_valid(cap_valid), .cap_bit(cap_bit)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit mo_h [0:4095];
  bit mi_h [0:4095];
  bit st_h [0:4095];
  int e_od = 0, e_id = 0, e_cap = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Entries {out delay, in delay, capture code}
  localparam logic [5:0] VECS [8] = '{
    6'b00_00_10, 6'b01_00_00, 6'b10_01_01, 6'b11_10_11,
    6'b00_11_10, 6'b10_11_00, 6'b01_01_11, 6'b11_00_01
  };

  function automatic bit hmo(input int i);
    return (i < 0) ? 1'b0 : mo_h[i];
  endfunction
  function automatic bit hmi(input int i);
    return (i < 0) ? 1'b0 : mi_h[i];
  endfunction

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input int od, input int id, input int cp);
    return {10'h2AB, 2'(cp), 2'(id), 2'(od), 16'h5A3C};
  endfunction

  task automatic tick(input bit mo, input bit mi, input bit st,
                      input bit we, input logic [31:0] wd, input bit ba);
    bit exp;
    @(negedge clk);
    mosi_core = mo; miso_pad = mi; sample_strobe = st;
    cfg_we = we; cfg_wdata = wd; burst_active = ba;
    mo_h[cyc] = mo; mi_h[cyc] = mi; st_h[cyc] = st;
    #1;
    exp = hmo(cyc - e_od);
    chk(mosi_pad === exp, "R2 output delay", mosi_pad, exp);
    if (cyc >= 2 && st_h[cyc-2]) begin
      chk(cap_valid === 1'b1, "R5 valid after pulse", cap_valid, 1'b1);
      exp = hmi(cyc - 4 + e_cap - e_id);
      chk(cap_bit === exp, "R3 R4 R7 captured bit", cap_bit, exp);
    end else begin
      chk(cap_valid === 1'b0, "R5 no valid", cap_valid, 1'b0);
    end
    if (we && !ba) begin
      e_od = int'(wd[17:16]); e_id = int'(wd[19:18]); e_cap = int'(wd[21:20]);
    end
    cyc++;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // mode 0: pulse every third cycle; mode 1: back-to-back pulses
  task automatic run_burst(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      bit st;
      step_lfsr();
      if (mode == 0) st = (i >= 6) && (i <= n - 6) && (i % 3 == 0);
      else           st = (i >= 6) && (i <= 12);
      tick(lfsr[0], lfsr[7], st, 1'b0, '0, 1'b1);
    end
  endtask

  task automatic write_cfg(input logic [31:0] wd);
    tick(1'b0, 1'b0, 1'b0, 1'b1, wd, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cap_valid === 1'b0, "R1 reset valid low", cap_valid, 1'b0);
    chk(mosi_pad === mosi_core, "R1 reset pass-through", mosi_pad, mosi_core);
    tick(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    chk(mosi_pad === 1'b1, "R1 zero output delay after reset", mosi_pad, 1'b1);
    // Reset config: capture two cycles early (covered by generic checks)
    run_burst(20, 0);

    // Table walk over delay/capture combinations
    foreach (VECS[v]) begin
      write_cfg(mkword(int'(VECS[v][5:4]), int'(VECS[v][3:2]), int'(VECS[v][1:0])));
      run_burst(30, 0);
    end

    // R6: write while busy is ignored
    write_cfg(mkword(0, 0, 2));
    tick(1'b0, 1'b0, 1'b0, 1'b1, mkword(3, 3, 3), 1'b1);
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    chk(mosi_pad === 1'b1, "R6 busy write ignored", mosi_pad, 1'b1);
    run_burst(24, 0);

    // R6: bits outside the fields have no effect
    write_cfg(32'hFFC0_FFFF);
    tick(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    chk(mosi_pad === 1'b0, "R6 outside bits ignored", mosi_pad, 1'b0);
    run_burst(24, 0);

    // R5: back-to-back pulses with late capture and maximum delays
    write_cfg(mkword(3, 3, 3));
    run_burst(20, 1);
    write_cfg(mkword(1, 2, 0));
    run_burst(20, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule